// File: doc/BRIEF.md
# Transceiver Start-Up and Reset Sequencer

This block steps a serial transceiver through its start-up timeline. It counts reference-clock cycles from the moment every hold-off input is low. As the count passes each threshold it releases the next group of analog controls: first the synthesizer is held at its lowest frequency, then the receiver analog loops are released, then the receiver begins tracking incoming data. At the end of the timeline the parallel receive data is declared valid and comma alignment is enabled. The thresholds are written in microseconds and converted to cycles from a reference-frequency parameter.

After start-up the block also handles two later events. When the receiver is told to idle on the reference, it idles and then relocks in a short fixed window. When low-power mode is entered and left, the whole timeline runs again. While a global reset is active, the block forces safe states: the serial line is driven idle, the loop filter and phase selector are cleared, and the parallel receive bus is frozen. A reset pulse that is too short is stretched to the minimum width. The analog circuits themselves are outside the block; it only produces their control levels and a phase code for status.

Top module: `xcvr_startup_seq`

## Requirements
- R1: The timeline starts only on the first clock edge at which `por`, `glb_rst` (including its stretch), `pll_bypass` and `low_power` are all low. Any of the first three being high returns `phase_code` to 0 and restarts the count from zero.
- R2: For the first SETTLE_US×REF_MHZ cycles of the timeline, `synth_min_freq` is 1 and `phase_code` is 1. `synth_min_freq` is also 1 in phase 0.
- R3: From SETTLE_US×REF_MHZ cycles, `rx_analog_en` is 1, with `phase_code` 2. It stays 1 in every later phase except 0, 1 and 8.
- R4: From LOCKIN_US×REF_MHZ cycles, `rx_track_en` is 1 and `phase_code` is 3. From ACQ_US×REF_MHZ cycles, `phase_code` is 4.
- R5: `rx_valid` and `comma_en` rise exactly READY_US×REF_MHZ cycles into the timeline, with `phase_code` 5.
- R6: When `lock_ref` is 0 at an edge in phase 5, the next phase is 6. In phase 6 `rx_track_en`, `rx_valid` and `comma_en` are 0 and `rx_hold` is 1. `lock_ref` has no effect during phases 1 to 4.
- R7: `lock_ref` returning to 1 in phase 6 gives phase 7. Phase 5 follows after RELOCK_US×REF_MHZ cycles. `lock_ref` at 0 during phase 7 goes back to phase 6.
- R8: While reset holds the block (`por` or stretched `glb_rst`), `tx_force_idle`, `rx_loop_reset` and `rx_hold` are 1. A bypass-only halt gives `rx_loop_reset` 1 and `tx_force_idle` 0.
- R9: A `glb_rst` pulse of any width holds the block in reset for at least RST_MIN_US×REF_MHZ cycles.
- R10: `low_power` (with no reset or bypass) gives phase 8 with `synth_pwrdn`, `rx_loop_reset` and `rx_hold` at 1. Leaving it re-runs the full timeline from zero.
- R11: `phase_code` encodes 0 halt, 1 settle, 2 synthesizer lock, 3 data acquire, 4 data confirm, 5 ready, 6 idle on reference, 7 relock, 8 sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| glb_rst | input | 1 | Global reset request, active high, stretched to minimum width |
| pll_bypass | input | 1 | Synthesizer bypass test mode; halts the timeline |
| low_power | input | 1 | Sleep request |
| lock_ref | input | 1 | 1 = track incoming data, 0 = idle on reference |
| synth_min_freq | output | 1 | Hold synthesizer at minimum frequency |
| synth_pwrdn | output | 1 | Synthesizer powered down |
| rx_analog_en | output | 1 | Receiver analog loops released |
| rx_track_en | output | 1 | Receiver tracks incoming data |
| rx_valid | output | 1 | Parallel receive data valid |
| comma_en | output | 1 | Comma detection and alignment enabled |
| tx_force_idle | output | 1 | Serial output forced to idle (true low, complement high) |
| rx_loop_reset | output | 1 | Loop filter and phase selector cleared |
| rx_hold | output | 1 | Parallel receive bus frozen |
| phase_code | output | 4 | Current phase code |

## Verification
The bench builds the block with REF_MHZ = 100, the low end of the reference range. This gives a full timeline of 35,800 cycles, so two complete start-ups, an idle/relock round with an interrupted relock, short and long reset pulses, a bypass halt and a sleep entered mid-timeline all fit in one run. The 100-cycle reset minimum and the 200-cycle relock window are short enough to count edge by edge. Every phase boundary is crossed with an exact cycle count.

// File: rtl/xcvr_seq_pkg.sv
package xcvr_seq_pkg;

    typedef enum logic [3:0] {
        PH_HALT    = 4'd0,
        PH_SETTLE  = 4'd1,
        PH_SYNTH   = 4'd2,
        PH_ACQ     = 4'd3,
        PH_CONFIRM = 4'd4,
        PH_READY   = 4'd5,
        PH_IDLE    = 4'd6,
        PH_RELOCK  = 4'd7,
        PH_SLEEP   = 4'd8
    } seq_phase_e;

    typedef struct packed {
        logic synth_min_freq;
        logic synth_pwrdn;
        logic rx_analog_en;
        logic rx_track_en;
        logic rx_valid;
        logic comma_en;
        logic tx_force_idle;
        logic rx_loop_reset;
        logic rx_hold;
    } seq_ctrl_t;

    function automatic int unsigned us_to_cycles(int unsigned us, int unsigned mhz);
        return us * mhz;
    endfunction

endpackage

// File: rtl/xcvr_rst_stretch.sv
module xcvr_rst_stretch #(
    parameter int unsigned MIN_CYC = 100
) (
    input  logic clk,
    input  logic por,
    input  logic glb_rst_i,
    output logic hold_o
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (por)
            left_q <= '0;
        else if (glb_rst_i)
            left_q <= CW'(MIN_CYC - 1);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign hold_o = glb_rst_i | (left_q != '0);

    assert_stretch_R9: assert property (@(posedge clk) disable iff (por)
        glb_rst_i |=> hold_o);

endmodule

// File: rtl/xcvr_seq_timeline.sv
module xcvr_seq_timeline
    import xcvr_seq_pkg::*;
#(
    parameter int unsigned T_SETTLE = 3200,
    parameter int unsigned T_LOCKIN = 26200,
    parameter int unsigned T_ACQ    = 32600,
    parameter int unsigned T_READY  = 35800,
    parameter int unsigned T_RELOCK = 200
) (
    input  logic       clk,
    input  logic       por,
    input  logic       hold_rst,
    input  logic       pll_bypass,
    input  logic       low_power,
    input  logic       lock_ref,
    output seq_phase_e phase_o,
    output logic       by_reset_o
);
    localparam int unsigned CW = $clog2(T_READY + 1);
    localparam int unsigned RW = $clog2(T_RELOCK + 1);
    localparam logic [CW-1:0] C_SETTLE = CW'(T_SETTLE);
    localparam logic [CW-1:0] C_LOCKIN = CW'(T_LOCKIN);
    localparam logic [CW-1:0] C_ACQ    = CW'(T_ACQ);
    localparam logic [CW-1:0] C_READY  = CW'(T_READY);
    localparam logic [RW-1:0] C_RL_END = RW'(T_RELOCK - 1);

    seq_phase_e    phase_q;
    logic          by_reset_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic [RW-1:0] rl_q;
    seq_phase_e    tl_phase;
    logic          stop;

    assign stop   = hold_rst | pll_bypass;
    assign cnt_nx = cnt_q + 1'b1;

    always_comb begin
        if (cnt_nx < C_SETTLE)      tl_phase = PH_SETTLE;
        else if (cnt_nx < C_LOCKIN) tl_phase = PH_SYNTH;
        else if (cnt_nx < C_ACQ)    tl_phase = PH_ACQ;
        else if (cnt_nx < C_READY)  tl_phase = PH_CONFIRM;
        else                        tl_phase = PH_READY;
    end

    always_ff @(posedge clk) begin
        if (por) begin
            phase_q    <= PH_HALT;
            by_reset_q <= 1'b1;
            cnt_q      <= '0;
            rl_q       <= '0;
        end else if (stop) begin
            phase_q    <= PH_HALT;
            by_reset_q <= hold_rst;
            cnt_q      <= '0;
            rl_q       <= '0;
        end else if (low_power) begin
            phase_q    <= PH_SLEEP;
            by_reset_q <= 1'b0;
            cnt_q      <= '0;
            rl_q       <= '0;
        end else begin
            by_reset_q <= 1'b0;
            unique case (phase_q)
                PH_HALT, PH_SLEEP: begin
                    phase_q <= PH_SETTLE;
                    cnt_q   <= '0;
                end
                PH_SETTLE, PH_SYNTH, PH_ACQ, PH_CONFIRM: begin
                    cnt_q   <= cnt_nx;
                    phase_q <= tl_phase;
                end
                PH_READY: begin
                    if (!lock_ref) phase_q <= PH_IDLE;
                end
                PH_IDLE: begin
                    if (lock_ref) begin
                        phase_q <= PH_RELOCK;
                        rl_q    <= '0;
                    end
                end
                PH_RELOCK: begin
                    if (!lock_ref)            phase_q <= PH_IDLE;
                    else if (rl_q == C_RL_END) phase_q <= PH_READY;
                    else                      rl_q    <= rl_q + 1'b1;
                end
                default: phase_q <= PH_HALT;
            endcase
        end
    end

    assign phase_o    = phase_q;
    assign by_reset_o = by_reset_q;

    assert_halt_on_stop_R1: assert property (@(posedge clk) disable iff (por)
        stop |=> (phase_q == PH_HALT));

    assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (por)
        (low_power && !stop) |=> (phase_q == PH_SLEEP));

    assert_ready_source_R5: assert property (@(posedge clk) disable iff (por)
        (phase_q == PH_READY && $past(phase_q) != PH_READY)
            |-> ($past(phase_q) == PH_CONFIRM || $past(phase_q) == PH_RELOCK));

    assert_idle_entry_R6: assert property (@(posedge clk) disable iff (por)
        (phase_q == PH_READY && !lock_ref && !stop && !low_power)
            |=> (phase_q == PH_IDLE));

    assert_relock_exit_R7: assert property (@(posedge clk) disable iff (por)
        (phase_q == PH_RELOCK && !lock_ref && !stop && !low_power)
            |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/xcvr_seq_decode.sv
module xcvr_seq_decode
    import xcvr_seq_pkg::*;
(
    input  seq_phase_e phase_i,
    input  logic       by_reset_i,
    output seq_ctrl_t  ctrl_o
);
    logic rst_halt;

    assign rst_halt = (phase_i == PH_HALT) & by_reset_i;

    always_comb begin
        ctrl_o = '0;
        ctrl_o.synth_min_freq = (phase_i == PH_HALT) || (phase_i == PH_SETTLE);
        ctrl_o.synth_pwrdn    = (phase_i == PH_SLEEP);
        ctrl_o.rx_analog_en   = (phase_i == PH_SYNTH)   || (phase_i == PH_ACQ) ||
                                (phase_i == PH_CONFIRM) || (phase_i == PH_READY) ||
                                (phase_i == PH_IDLE)    || (phase_i == PH_RELOCK);
        ctrl_o.rx_track_en    = (phase_i == PH_ACQ)   || (phase_i == PH_CONFIRM) ||
                                (phase_i == PH_READY) || (phase_i == PH_RELOCK);
        ctrl_o.rx_valid       = (phase_i == PH_READY);
        ctrl_o.comma_en       = (phase_i == PH_READY);
        ctrl_o.tx_force_idle  = rst_halt;
        ctrl_o.rx_loop_reset  = (phase_i == PH_HALT) || (phase_i == PH_SLEEP);
        ctrl_o.rx_hold        = rst_halt || (phase_i == PH_IDLE) || (phase_i == PH_SLEEP);
    end

endmodule

// File: rtl/xcvr_startup_seq.sv
module xcvr_startup_seq
    import xcvr_seq_pkg::*;
#(
    parameter int unsigned REF_MHZ    = 125,
    parameter int unsigned SETTLE_US  = 32,
    parameter int unsigned LOCKIN_US  = 262,
    parameter int unsigned ACQ_US     = 326,
    parameter int unsigned READY_US   = 358,
    parameter int unsigned RELOCK_US  = 2,
    parameter int unsigned RST_MIN_US = 1
) (
    input  logic       clk,
    input  logic       por,
    input  logic       glb_rst,
    input  logic       pll_bypass,
    input  logic       low_power,
    input  logic       lock_ref,
    output logic       synth_min_freq,
    output logic       synth_pwrdn,
    output logic       rx_analog_en,
    output logic       rx_track_en,
    output logic       rx_valid,
    output logic       comma_en,
    output logic       tx_force_idle,
    output logic       rx_loop_reset,
    output logic       rx_hold,
    output logic [3:0] phase_code
);
    localparam int unsigned T_SETTLE = us_to_cycles(SETTLE_US, REF_MHZ);
    localparam int unsigned T_LOCKIN = us_to_cycles(LOCKIN_US, REF_MHZ);
    localparam int unsigned T_ACQ    = us_to_cycles(ACQ_US, REF_MHZ);
    localparam int unsigned T_READY  = us_to_cycles(READY_US, REF_MHZ);
    localparam int unsigned T_RELOCK = us_to_cycles(RELOCK_US, REF_MHZ);
    localparam int unsigned T_RSTMIN = us_to_cycles(RST_MIN_US, REF_MHZ);

    logic       hold_rst;
    seq_phase_e phase;
    logic       by_reset;
    seq_ctrl_t  ctrl;

    xcvr_rst_stretch #(.MIN_CYC(T_RSTMIN)) u_stretch (
        .clk       (clk),
        .por       (por),
        .glb_rst_i (glb_rst),
        .hold_o    (hold_rst)
    );

    xcvr_seq_timeline #(
        .T_SETTLE (T_SETTLE),
        .T_LOCKIN (T_LOCKIN),
        .T_ACQ    (T_ACQ),
        .T_READY  (T_READY),
        .T_RELOCK (T_RELOCK)
    ) u_timeline (
        .clk        (clk),
        .por        (por),
        .hold_rst   (hold_rst),
        .pll_bypass (pll_bypass),
        .low_power  (low_power),
        .lock_ref   (lock_ref),
        .phase_o    (phase),
        .by_reset_o (by_reset)
    );

    xcvr_seq_decode u_decode (
        .phase_i    (phase),
        .by_reset_i (by_reset),
        .ctrl_o     (ctrl)
    );

    assign synth_min_freq = ctrl.synth_min_freq;
    assign synth_pwrdn    = ctrl.synth_pwrdn;
    assign rx_analog_en   = ctrl.rx_analog_en;
    assign rx_track_en    = ctrl.rx_track_en;
    assign rx_valid       = ctrl.rx_valid;
    assign comma_en       = ctrl.comma_en;
    assign tx_force_idle  = ctrl.tx_force_idle;
    assign rx_loop_reset  = ctrl.rx_loop_reset;
    assign rx_hold        = ctrl.rx_hold;
    assign phase_code     = phase;

    assert_track_after_analog_R4: assert property (@(posedge clk) disable iff (por)
        $rose(rx_track_en) |-> rx_analog_en);

    assert_reset_forces_idle_R8: assert property (@(posedge clk) disable iff (por)
        (glb_rst && !pll_bypass) |=> (tx_force_idle && rx_hold && !rx_valid));

endmodule

// File: tb/xcvr_startup_seq_test.sv
module xcvr_startup_seq_test;

    localparam int MHZ     = 100;
    localparam int T1      = 32 * MHZ;
    localparam int T2      = 262 * MHZ;
    localparam int T3      = 326 * MHZ;
    localparam int T4      = 358 * MHZ;
    localparam int TRL     = 2 * MHZ;
    localparam int TRST    = 1 * MHZ;

    logic clk = 1'b0;
    logic por, glb_rst, pll_bypass, low_power, lock_ref;
    logic synth_min_freq, synth_pwrdn, rx_analog_en, rx_track_en, rx_valid;
    logic comma_en, tx_force_idle, rx_loop_reset, rx_hold;
    logic [3:0] phase_code;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit done   = 1'b0;

    // behavioural reference state
    int m_ph = 0;
    int m_rsn = 1;
    int m_t = 0;
    int m_rl = 0;
    int m_rc = 0;

    always #4 clk = ~clk;

    xcvr_startup_seq #(.REF_MHZ(MHZ)) uut (
        .clk(clk), .por(por), .glb_rst(glb_rst), .pll_bypass(pll_bypass),
        .low_power(low_power), .lock_ref(lock_ref),
        .synth_min_freq(synth_min_freq), .synth_pwrdn(synth_pwrdn),
        .rx_analog_en(rx_analog_en), .rx_track_en(rx_track_en),
        .rx_valid(rx_valid), .comma_en(comma_en), .tx_force_idle(tx_force_idle),
        .rx_loop_reset(rx_loop_reset), .rx_hold(rx_hold), .phase_code(phase_code)
    );

    function automatic int ph_of(int t);
        if (t < T1) return 1;
        if (t < T2) return 2;
        if (t < T3) return 3;
        if (t < T4) return 4;
        return 5;
    endfunction

    always @(posedge clk) begin
        bit hold;
        hold = glb_rst || (m_rc > 0);
        if (por) m_rc = 0;
        else if (glb_rst) m_rc = TRST - 1;
        else if (m_rc > 0) m_rc = m_rc - 1;
        if (por) begin m_ph = 0; m_rsn = 1; m_t = 0; end
        else if (hold || pll_bypass) begin m_ph = 0; m_rsn = hold ? 1 : 0; m_t = 0; end
        else if (low_power) begin m_ph = 8; m_rsn = 0; m_t = 0; end
        else begin
            m_rsn = 0;
            if (m_ph == 0 || m_ph == 8) begin m_ph = 1; m_t = 0; end
            else if (m_ph >= 1 && m_ph <= 4) begin m_t++; m_ph = ph_of(m_t); end
            else if (m_ph == 5) begin if (!lock_ref) m_ph = 6; end
            else if (m_ph == 6) begin if (lock_ref) begin m_ph = 7; m_rl = 0; end end
            else if (m_ph == 7) begin
                if (!lock_ref) m_ph = 6;
                else begin m_rl++; if (m_rl == TRL) m_ph = 5; end
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            bit rh;
            rh = (m_ph == 0) && (m_rsn == 1);
            chk(phase_code, m_ph, "R11", "phase_code");
            chk(synth_min_freq, (m_ph == 0 || m_ph == 1), "R2", "synth_min_freq");
            chk(rx_analog_en, (m_ph >= 2 && m_ph <= 7), "R3", "rx_analog_en");
            chk(rx_track_en, (m_ph == 3 || m_ph == 4 || m_ph == 5 || m_ph == 7), "R4", "rx_track_en");
            chk(rx_valid, (m_ph == 5), "R5", "rx_valid");
            chk(comma_en, (m_ph == 5), "R5", "comma_en");
            chk(tx_force_idle, rh, "R8", "tx_force_idle");
            chk(rx_loop_reset, (m_ph == 0 || m_ph == 8), "R8", "rx_loop_reset");
            chk(rx_hold, (rh || m_ph == 6 || m_ph == 8), "R6", "rx_hold");
            chk(synth_pwrdn, (m_ph == 8), "R10", "synth_pwrdn");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (phase_code != 4'd5 && n < 40000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        por = 1; glb_rst = 0; pll_bypass = 0; low_power = 0; lock_ref = 1;
        cyc(3);
        chk_en = 1;
        chk(phase_code, 0, "R11", "reset phase");
        chk(tx_force_idle, 1, "R8", "reset tx idle");
        chk(rx_valid, 0, "R5", "reset valid");

        // R1, R5, R6: full start-up, lock_ref wiggle ignored during timeline
        por = 0;
        cyc(1000); lock_ref = 0; cyc(100); lock_ref = 1;
        n = 1000 + 100;
        begin int k; wait_ready(k); n += k; end
        chk(n, T4 + 1, "R5", "cycles to ready");

        // R6 idle, R7 relock
        lock_ref = 0; cyc(1);
        chk(phase_code, 6, "R6", "idle entry");
        cyc(50); lock_ref = 1;
        wait_ready(n);
        chk(n, TRL + 1, "R7", "relock window");
        lock_ref = 0; cyc(20); lock_ref = 1; cyc(50); lock_ref = 0; cyc(5);
        chk(phase_code, 6, "R7", "relock interrupted");
        lock_ref = 1; wait_ready(n);
        chk(n, TRL + 1, "R7", "relock after interrupt");

        // R9: single-cycle reset stretched
        glb_rst = 1; cyc(1); glb_rst = 0;
        n = tx_force_idle ? 1 : 0;
        for (int i = 0; i < 150; i++) begin cyc(1); if (tx_force_idle) n++; end
        chk(n, TRST, "R9", "stretched reset width");
        glb_rst = 1; cyc(300); glb_rst = 0; cyc(2000);

        // R1: bypass halts without forcing serial idle
        pll_bypass = 1; cyc(20);
        chk(phase_code, 0, "R1", "bypass halt");
        chk(tx_force_idle, 0, "R8", "bypass no tx idle");
        pll_bypass = 0; cyc(5000);

        // R10: sleep mid-timeline then full rerun
        low_power = 1; cyc(100);
        chk(synth_pwrdn, 1, "R10", "sleep powerdown");
        low_power = 0;
        wait_ready(n);
        chk(n, T4 + 1, "R10", "rerun after sleep");
        cyc(10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule